// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A global history register records the outcomes of the most recent branches, with 1 for taken and 0 for not taken. That history picks one of several banks of saturating counters. The low-order bits of the branch address then pick a counter inside that bank. The most significant bit of that counter is the prediction. The history depth and the counter width are fixed when the design is elaborated. A depth of zero turns the block into a plain address-indexed counter table.

The front end of a pipeline drives a branch address on the predict port and reads the taken/not-taken guess in the same cycle. When a branch resolves, the back end drives the update port with the branch address and its real outcome. That trains the one counter chosen by the current history and address, and then shifts the outcome into the history. The table stores no tags, so branches whose index bits are equal share counters.

Top module: `corr_branch_predictor`

## Requirements
- R1: A synchronous active-high reset clears the history to all zeros and sets every counter to the weakly-not-taken value 2^(n-1)-1. After reset every address predicts not taken.
- R2: The prediction is combinational and equals the most significant bit of the counter at index {history, pc[PC_SHIFT +: IDX_BITS]}. The history sits in the upper index bits.
- R3: A taken update increments the selected counter. A counter at 2^n-1 stays there.
- R4: A not-taken update decrements the selected counter. A counter at 0 stays there.
- R5: An update changes only the selected counter. Counters at other addresses, and counters of the same address under other histories, keep their values.
- R6: A valid update shifts the outcome into history bit 0 and moves older outcomes one place toward the most significant bit. Taken is written as 1.
- R7: When a prediction and an update fall in the same cycle, the prediction uses the history and counter values from before the update.
- R8: There is no tag check. Two addresses that differ only outside the index bits read and train the same counters.
- R9: With n=2, a counter in a strongly taken state keeps predicting taken after one not-taken update. It flips only after a second one.
- R10: While upd_valid is low, the counters and the history keep their values, whatever upd_pc and upd_taken are.
- R11: With m=2, a branch whose outcome depends on the two previous branch outcomes is predicted correctly once each history pattern has been trained.
- R12: With m=0, the block behaves exactly as a single table of n-bit counters indexed by the address bits alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Prediction for pred_pc: 1 = taken |
| upd_valid | input | 1 | The update port carries a resolved branch this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 = taken |

## Verification
The assertions take upd_pc and upd_taken to be known values whenever upd_valid is high. They also assume that reset is held for at least one clock edge before the first update. The stimulus meets both: it holds reset for several cycles, then drives every input on the falling edge, and updates only at addresses it has just predicted or has chosen on purpose to alias. The counter saturation checks rely on the update index staying stable for the cycle they observe. The bench keeps each update for exactly one rising edge and then drops upd_valid.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic {
        DIR_NT = 1'b0,
        DIR_T  = 1'b1
    } dir_e;

    typedef struct packed {
        logic vld;
        dir_e outcome;
    } upd_ev_t;

    function automatic int unsigned weak_nt_val(input int unsigned nbits);
        return (32'd1 << (nbits - 1)) - 32'd1;
    endfunction

    function automatic int unsigned hist_width(input int unsigned mbits);
        return (mbits == 0) ? 1 : mbits;
    endfunction

endpackage

// File: rtl/gbp_history.sv
module gbp_history
    import gbp_pkg::*;
#(
    parameter int unsigned M  = 2,
    parameter int unsigned HW = hist_width(M)
) (
    input  logic          clk,
    input  logic          rst,
    input  upd_ev_t       ev,
    output logic [HW-1:0] hist
);

    generate
        if (M == 0) begin : g_none
            logic unused_hist_in;
            assign unused_hist_in = ^{clk, rst, ev};
            assign hist = '0;
        end else begin : g_shift
            if (M == 1) begin : g_one
                always_ff @(posedge clk) begin
                    if (rst)         hist <= '0;
                    else if (ev.vld) hist <= ev.outcome;
                end
            end else begin : g_many
                always_ff @(posedge clk) begin
                    if (rst)         hist <= '0;
                    else if (ev.vld) hist <= {hist[HW-2:0], ev.outcome};
                end
            end

            // R6
            hist_shift_in_chk: assert property (@(posedge clk) disable iff (rst)
                ev.vld |=> hist[0] == $past(ev.outcome));

            // R10
            hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !ev.vld |=> $stable(hist));
        end
    endgenerate

endmodule

// File: rtl/gbp_index.sv
module gbp_index #(
    parameter int unsigned M        = 2,
    parameter int unsigned HW       = 2,
    parameter int unsigned IDX_BITS = 4,
    parameter int unsigned PC_W     = 32,
    parameter int unsigned PC_SHIFT = 2,
    parameter int unsigned AW       = M + IDX_BITS
) (
    input  logic [HW-1:0]   hist,
    input  logic [PC_W-1:0] pc,
    output logic [AW-1:0]   addr
);

    logic [IDX_BITS-1:0] pc_idx;
    logic                unused_idx_in;

    assign pc_idx        = pc[PC_SHIFT +: IDX_BITS];
    assign unused_idx_in = ^{pc, hist};

    generate
        if (M == 0) begin : g_flat
            assign addr = pc_idx;
        end else begin : g_corr
            assign addr = {hist[M-1:0], pc_idx};
        end
    endgenerate

endmodule

// File: rtl/gbp_ctr_table.sv
module gbp_ctr_table
    import gbp_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned N  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr,
    output logic [N-1:0]  rdata,
    input  upd_ev_t       ev,
    input  logic [AW-1:0] waddr
);

    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [N-1:0] MAXV = '1;
    localparam logic [N-1:0] INIT = N'(weak_nt_val(N));

    logic [N-1:0] mem [DEPTH];
    logic [N-1:0] cur;
    logic [N-1:0] nxt;

    assign rdata = mem[raddr];
    assign cur   = mem[waddr];

    always_comb begin
        if (ev.outcome == DIR_T) nxt = (cur == MAXV) ? cur : cur + 1'b1;
        else                     nxt = (cur == '0)   ? cur : cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
        end else if (ev.vld) begin
            mem[waddr] <= nxt;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.vld && ev.outcome == DIR_T && mem[waddr] == MAXV)
        |=> mem[$past(waddr)] == MAXV);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.vld && ev.outcome == DIR_NT && mem[waddr] == '0)
        |=> mem[$past(waddr)] == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev.vld |=> mem[$past(waddr)] == $past(mem[waddr]));

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
    import gbp_pkg::*;
#(
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned CTR_BITS  = 2,
    parameter int unsigned IDX_BITS  = 4,
    parameter int unsigned PC_W      = 32,
    parameter int unsigned PC_SHIFT  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int unsigned HW = hist_width(HIST_BITS);
    localparam int unsigned AW = HIST_BITS + IDX_BITS;

    upd_ev_t             ev;
    logic [HW-1:0]       hist;
    logic [AW-1:0]       rd_addr;
    logic [AW-1:0]       wr_addr;
    logic [CTR_BITS-1:0] rd_ctr;
    logic                rst_d;

    assign ev.vld     = upd_valid;
    assign ev.outcome = upd_taken ? DIR_T : DIR_NT;

    gbp_history #(.M(HIST_BITS), .HW(HW)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .hist (hist)
    );

    gbp_index #(
        .M(HIST_BITS), .HW(HW), .IDX_BITS(IDX_BITS),
        .PC_W(PC_W), .PC_SHIFT(PC_SHIFT), .AW(AW)
    ) u_pred_idx (
        .hist (hist),
        .pc   (pred_pc),
        .addr (rd_addr)
    );

    gbp_index #(
        .M(HIST_BITS), .HW(HW), .IDX_BITS(IDX_BITS),
        .PC_W(PC_W), .PC_SHIFT(PC_SHIFT), .AW(AW)
    ) u_upd_idx (
        .hist (hist),
        .pc   (upd_pc),
        .addr (wr_addr)
    );

    gbp_ctr_table #(.AW(AW), .N(CTR_BITS)) u_table (
        .clk   (clk),
        .rst   (rst),
        .raddr (rd_addr),
        .rdata (rd_ctr),
        .ev    (ev),
        .waddr (wr_addr)
    );

    assign pred_taken = rd_ctr[CTR_BITS-1];

    always_ff @(posedge clk) rst_d <= rst;

    // R1
    reset_predicts_nt_chk: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> !pred_taken);

endmodule

// File: tb/corr_branch_predictor_bench.sv
module corr_branch_predictor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pred_pc = '0;
    logic [31:0] upd_pc = '0;
    logic        upd_valid = 1'b0;
    logic        upd_taken = 1'b0;
    logic        pred_a;
    logic        pred_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    corr_branch_predictor u_corr_branch_predictor (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_a),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    corr_branch_predictor #(.HIST_BITS(0)) u_corr_branch_predictor_m0 (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_b),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // reference models: m=2/n=2 and m=0/n=2
    bit [1:0] mdl_a [64];
    bit [1:0] mdl_b [16];
    bit [1:0] hist_a;

    typedef struct {
        bit    exp_a;
        bit    exp_b;
        bit    lit_en;
        bit    lit_b;
        bit    lit_v;
        string req;
    } item_t;

    item_t q[$];

    function automatic bit [1:0] sat(input bit [1:0] v, input bit t);
        if (t) return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    task automatic step(input logic [31:0] ppc, input bit uv, input logic [31:0] upc,
                        input bit ut, input string req,
                        input bit len = 0, input bit lb = 0, input bit lv = 0);
        item_t it;
        @(negedge clk);
        pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        it.exp_a  = mdl_a[{hist_a, ppc[5:2]}][1];
        it.exp_b  = mdl_b[ppc[5:2]][1];
        it.lit_en = len; it.lit_b = lb; it.lit_v = lv; it.req = req;
        q.push_back(it);
        if (uv) begin
            mdl_a[{hist_a, upc[5:2]}] = sat(mdl_a[{hist_a, upc[5:2]}], ut);
            mdl_b[upc[5:2]] = sat(mdl_b[upc[5:2]], ut);
            hist_a = {hist_a[0], ut};
        end
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    // monitor: pops expected items and compares
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (pred_a !== it.exp_a) begin
                    errors++;
                    $display("FAIL R2 (%s) main model: actual %0b expected %0b", it.req, pred_a, it.exp_a);
                end
                checks++;
                if (pred_b !== it.exp_b) begin
                    errors++;
                    $display("FAIL R12 (%s) flat model: actual %0b expected %0b", it.req, pred_b, it.exp_b);
                end
                if (it.lit_en) begin
                    checks++;
                    if ((it.lit_b ? pred_b : pred_a) !== it.lit_v) begin
                        errors++;
                        $display("FAIL %s: actual %0b expected %0b", it.req,
                                 it.lit_b ? pred_b : pred_a, it.lit_v);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl_a[i] = 2'd1;
        for (int i = 0; i < 16; i++) mdl_b[i] = 2'd1;
        hist_a = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: every address predicts not taken after reset
        for (int k = 0; k < 16; k++) step(32'(k * 4), 0, 0, 0, "R1", 1, 0, 0);
        for (int k = 0; k < 16; k++) step(32'(k * 4), 0, 0, 0, "R1", 1, 1, 0);

        // R10: idle update port with taken outcome changes nothing
        for (int k = 0; k < 4; k++) step(32'h24, 0, 32'h24, 1, "R10");
        step(32'h24, 0, 0, 0, "R10", 1, 0, 0);
        step(32'h24, 0, 0, 0, "R10", 1, 1, 0);

        // R3/R4/R9 on the flat instance, PC index 0
        step(32'h40, 1, 32'h40, 1, "R3", 1, 1, 0);
        step(32'h40, 1, 32'h40, 1, "R3", 1, 1, 1);
        step(32'h40, 1, 32'h40, 1, "R3", 1, 1, 1);
        step(32'h40, 1, 32'h40, 1, "R3", 1, 1, 1);
        step(32'h40, 1, 32'h40, 1, "R3", 1, 1, 1);
        step(32'h40, 1, 32'h40, 0, "R9", 1, 1, 1);
        step(32'h40, 1, 32'h40, 0, "R9", 1, 1, 1);
        step(32'h40, 1, 32'h40, 0, "R9", 1, 1, 0);
        step(32'h40, 1, 32'h40, 0, "R4", 1, 1, 0);
        step(32'h40, 1, 32'h40, 0, "R4", 1, 1, 0);
        step(32'h40, 1, 32'h40, 1, "R4", 1, 1, 0);
        step(32'h40, 1, 32'h40, 1, "R4", 1, 1, 0);
        step(32'h40, 0, 0, 0, "R4", 1, 1, 1);

        // R8: aliasing through high address bits
        for (int k = 0; k < 3; k++) step(32'h0010_0010, 1, 32'h0010_0010, 1, "R8");
        step(32'h0000_0010, 0, 0, 0, "R8", 1, 1, 1);

        // R6/R7: alternating single branch, prediction and update together
        for (int r = 0; r < 16; r++)
            step(32'h30, 1, 32'h30, r[0], "R7", r >= 6, 0, r[0]);

        // R11: branch A taken only when B and C were both not taken
        for (int r = 0; r < 12; r++) begin
            step(32'h204, 1, 32'h204, r[0], "R6");
            step(32'h208, 1, 32'h208, 0, "R6");
            step(32'h20C, 1, 32'h20C, !r[0], "R11", r >= 6, 0, !r[0]);
        end

        // R5: sweep all addresses under the current history
        for (int k = 0; k < 16; k++) step(32'(k * 4), 0, 0, 0, "R5");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule